// File: doc/BRIEF.md
# External Bus Access Sequencer

This block turns single read or write requests into strobe sequences on an asynchronous external memory bus. Every access runs through three timed phases, lead, active and trail, each counted in cycles of the internal timing clock. Reads and writes carry separate phase lengths. The block drives an active-low chip select, an active-low read strobe, an active-low write strobe, a read/not-write line and a 19-bit address. The 16-bit data bus is presented as separate output, output-enable and input signals so that the pad ring can build the tri-state driver.

The bus clock seen by external devices runs either at the timing-clock rate or at half of it. The lead phase of an access must start on a rising bus-clock edge. In half-rate mode a request that arrives out of phase therefore gets one alignment cycle in front of it, and every control line stays inactive during that cycle. When enabled, an external ready input can stretch the active phase. The address is never cleared between accesses. Write data stays on the bus through the whole trail phase. Read data is captured from the bus at the end of the active phase.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, csN, rdN, weN and rnw are 1, busDoe is 0, idle is 1, done is 0, and busAddr and rdData are 0.
- R2: An accepted access asserts csN low for lead + active + trail cycles, using the write fields when reqWrite=1 and the read fields otherwise. A lead field of 0 gives one lead cycle, and a field value N>0 gives N cycles.
- R3: busRise is 1 in every cycle when halfRate=0. When halfRate=1 it is 1 in the first cycle after reset and alternates every cycle. The first lead cycle of every access has busRise=1.
- R4: When halfRate=1 and the cycle after acceptance would have busRise=0, exactly one alignment cycle is inserted before the lead phase. In that cycle csN, rdN, weN and rnw are all 1.
- R5: With useReady=0, readyIn has no effect, and the active phase lasts exactly its programmed length.
- R6: With useReady=1 and a non-zero active length, readyIn is sampled in the last active cycle. Each sample of 0 adds one more active cycle. With an active length of 0, readyIn is ignored.
- R7: busAddr loads reqAddr only when a request is accepted, and keeps that value through alignment, idle and done cycles.
- R8: During a write, weN is 0 in the active cycles, and rnw is 0 and busDoe is 1 in the active and trail cycles. In those cycles busDout equals the accepted reqWdata.
- R9: During a read, rdN is 0 in the active cycles, and rnw stays 1. rdData captures busDin in the last active cycle, or in the last lead cycle when the active length is 0. rdData holds that value until the next read capture.
- R10: done is 1 for exactly one cycle, the cycle after the last phase cycle, and idle is 1 in that cycle.
- R11: reqValid is ignored while idle is 0. Such a request changes neither busAddr nor the running sequence.
- R12: A phase whose programmed length is 0 is skipped, and the sequence goes straight to the next non-empty phase or finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request, accepted when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Access address |
| reqWdata | input | 16 | Write data |
| rdLead | input | 4 | Read lead length |
| rdActive | input | 4 | Read active length |
| rdTrail | input | 4 | Read trail length |
| wrLead | input | 4 | Write lead length |
| wrActive | input | 4 | Write active length |
| wrTrail | input | 4 | Write trail length |
| useReady | input | 1 | Enable active-phase stretching by readyIn |
| halfRate | input | 1 | Bus clock at half the timing clock |
| readyIn | input | 1 | External ready, high = ready |
| busDin | input | 16 | Data bus input from pad |
| idle | output | 1 | Sequencer can accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Captured read data |
| busRise | output | 1 | Cycle begins on a rising bus-clock edge |
| csN | output | 1 | Chip select, active low |
| rdN | output | 1 | Read strobe, active low |
| weN | output | 1 | Write strobe, active low |
| rnw | output | 1 | High for read, low while write data is presented |
| busAddr | output | 19 | Address bus |
| busDout | output | 16 | Data bus output to pad |
| busDoe | output | 1 | Data bus output enable |

## Verification
The embedded properties check several things on every cycle. A chip-select fall only happens on a rising bus-clock cycle, and alignment cycles keep all controls inactive. The read and write strobes never overlap. The active phase ends on time without ready and stretches while ready is low. done never lasts two cycles. The address, write data and read data only change on their load strobes. The exact phase lengths per direction, the skipping of empty phases, the alignment decision at both clock parities, the captured read value and the refusal of requests while busy can only be shown by the bench's access scenarios, which compare every cycle against an independently computed phase sequence.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_LEAD,
    ST_ACTIVE,
    ST_TRAIL
  } phase_e;

  typedef struct packed {
    logic loadReq;
    logic captureRd;
    logic driveData;
  } dpStrobe_t;

endpackage

// File: rtl/ebs_ctrl.sv
module ebs_ctrl
  import ebs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [CNT_W-1:0] rdLead,
  input  logic [CNT_W-1:0] rdActive,
  input  logic [CNT_W-1:0] rdTrail,
  input  logic [CNT_W-1:0] wrLead,
  input  logic [CNT_W-1:0] wrActive,
  input  logic [CNT_W-1:0] wrTrail,
  input  logic             useReady,
  input  logic             halfRate,
  input  logic             readyIn,
  output dpStrobe_t        strobe,
  output logic             idle,
  output logic             done,
  output logic             busRise,
  output logic             csN,
  output logic             rdN,
  output logic             weN,
  output logic             rnw
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [CNT_W-1:0] lenAct, lenTrail;
  logic [CNT_W-1:0] selLead, leadEff;
  logic             isWr, phaseBit, doneReg;
  logic             accept, finish, captureRd, readyHold;

  assign selLead   = reqWrite ? wrLead : rdLead;
  assign leadEff   = (selLead == '0) ? ONE : selLead;
  assign accept    = (state == ST_IDLE) && reqValid;
  assign readyHold = useReady && !readyIn;

  always_comb begin
    stateNxt  = state;
    cntNxt    = cnt;
    finish    = 1'b0;
    captureRd = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stateNxt = (halfRate && !phaseBit) ? ST_ALIGN : ST_LEAD;
          cntNxt   = leadEff - ONE;
        end
      end
      ST_ALIGN: stateNxt = ST_LEAD;
      ST_LEAD: begin
        if (cnt != '0) begin
          cntNxt = cnt - ONE;
        end else begin
          captureRd = !isWr && (lenAct == '0);
          if (lenAct != '0) begin
            stateNxt = ST_ACTIVE;
            cntNxt   = lenAct - ONE;
          end else if (lenTrail != '0) begin
            stateNxt = ST_TRAIL;
            cntNxt   = lenTrail - ONE;
          end else begin
            stateNxt = ST_IDLE;
            finish   = 1'b1;
          end
        end
      end
      ST_ACTIVE: begin
        if (cnt != '0) begin
          cntNxt = cnt - ONE;
        end else if (!readyHold) begin
          captureRd = !isWr;
          if (lenTrail != '0) begin
            stateNxt = ST_TRAIL;
            cntNxt   = lenTrail - ONE;
          end else begin
            stateNxt = ST_IDLE;
            finish   = 1'b1;
          end
        end
      end
      ST_TRAIL: begin
        if (cnt != '0) begin
          cntNxt = cnt - ONE;
        end else begin
          stateNxt = ST_IDLE;
          finish   = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lenAct   <= '0;
      lenTrail <= '0;
      isWr     <= 1'b0;
      phaseBit <= 1'b0;
      doneReg  <= 1'b0;
    end else begin
      state    <= stateNxt;
      cnt      <= cntNxt;
      phaseBit <= ~phaseBit;
      doneReg  <= finish;
      if (accept) begin
        isWr     <= reqWrite;
        lenAct   <= reqWrite ? wrActive : rdActive;
        lenTrail <= reqWrite ? wrTrail : rdTrail;
      end
    end
  end

  assign strobe.loadReq   = accept;
  assign strobe.captureRd = captureRd;
  assign strobe.driveData = isWr && ((state == ST_ACTIVE) || (state == ST_TRAIL));

  assign idle    = (state == ST_IDLE);
  assign done    = doneReg;
  assign busRise = halfRate ? ~phaseBit : 1'b1;
  assign csN     = !((state == ST_LEAD) || (state == ST_ACTIVE) || (state == ST_TRAIL));
  assign rdN     = !((state == ST_ACTIVE) && !isWr);
  assign weN     = !((state == ST_ACTIVE) && isWr);
  assign rnw     = !(isWr && ((state == ST_ACTIVE) || (state == ST_TRAIL)));

  AST_LEAD_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> busRise);  // R3
  AST_ALIGN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ALIGN) |-> (csN && rdN && weN && rnw));  // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~rdN, ~weN}));  // R2
  AST_NO_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && cnt == '0 && !useReady) |=> (state != ST_ACTIVE));  // R5
  AST_READY_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && cnt == '0 && useReady && !readyIn) |=> (state == ST_ACTIVE));  // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R10

endmodule

// File: rtl/ebs_datapath.sv
module ebs_datapath
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDin,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoe,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg, rdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdReg    <= '0;
    end else begin
      if (strobe.loadReq) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (strobe.captureRd) rdReg <= busDin;
    end
  end

  assign busAddr = addrReg;
  assign busDout = wdataReg;
  assign busDoe  = strobe.driveData;
  assign rdData  = rdReg;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadReq |=> $stable(busAddr));  // R7
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.driveData |=> (!strobe.driveData || $stable(busDout)));  // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureRd |=> $stable(rdData));  // R9

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [CNT_W-1:0]  rdLead,
  input  logic [CNT_W-1:0]  rdActive,
  input  logic [CNT_W-1:0]  rdTrail,
  input  logic [CNT_W-1:0]  wrLead,
  input  logic [CNT_W-1:0]  wrActive,
  input  logic [CNT_W-1:0]  wrTrail,
  input  logic              useReady,
  input  logic              halfRate,
  input  logic              readyIn,
  input  logic [DATA_W-1:0] busDin,
  output logic              idle,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              busRise,
  output logic              csN,
  output logic              rdN,
  output logic              weN,
  output logic              rnw,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoe
);

  dpStrobe_t strobe;

  ebs_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .rdLead(rdLead), .rdActive(rdActive), .rdTrail(rdTrail),
    .wrLead(wrLead), .wrActive(wrActive), .wrTrail(wrTrail),
    .useReady(useReady), .halfRate(halfRate), .readyIn(readyIn),
    .strobe(strobe), .idle(idle), .done(done), .busRise(busRise),
    .csN(csN), .rdN(rdN), .weN(weN), .rnw(rnw)
  );

  ebs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busDin(busDin), .busAddr(busAddr),
    .busDout(busDout), .busDoe(busDoe), .rdData(rdData)
  );

endmodule

// File: tb/ext_bus_seq_tb_top.sv
module ext_bus_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [3:0]  rdLead = '0, rdActive = '0, rdTrail = '0;
  logic [3:0]  wrLead = '0, wrActive = '0, wrTrail = '0;
  logic        useReady = 1'b0, halfRate = 1'b0, readyIn = 1'b1;
  logic [15:0] busDin = '0;
  logic        idle, done, busRise, csN, rdN, weN, rnw, busDoe;
  logic [15:0] rdData, busDout;
  logic [18:0] busAddr;

  int unsigned cyc = 0;
  int          nChecks = 0, nFails = 0;
  logic [15:0] expRd = '0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  ext_bus_seq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdLead(rdLead), .rdActive(rdActive), .rdTrail(rdTrail),
    .wrLead(wrLead), .wrActive(wrActive), .wrTrail(wrTrail),
    .useReady(useReady), .halfRate(halfRate), .readyIn(readyIn),
    .busDin(busDin), .idle(idle), .done(done), .rdData(rdData),
    .busRise(busRise), .csN(csN), .rdN(rdN), .weN(weN), .rnw(rnw),
    .busAddr(busAddr), .busDout(busDout), .busDoe(busDoe)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  function automatic bit riseExpected(input bit hr, input int unsigned c);
    return !hr || (c % 2 == 0);
  endfunction

  // phase codes in the bench model: 1 align, 2 lead, 3 active, 4 trail
  task automatic runAccess(input bit wr, input logic [18:0] a, input logic [15:0] d,
                           input int L, input int A, input int T, input bit ur,
                           input bit hr, input int lowPct, input bit noise);
    int st, leadLeft, actLeft, trLeft, guard;
    bit endNow, firstLead;
    if (wr) begin
      wrLead = 4'(L); wrActive = 4'(A); wrTrail = 4'(T);
      rdLead = 4'($urandom); rdActive = 4'($urandom); rdTrail = 4'($urandom);
    end else begin
      rdLead = 4'(L); rdActive = 4'(A); rdTrail = 4'(T);
      wrLead = 4'($urandom); wrActive = 4'($urandom); wrTrail = 4'($urandom);
    end
    useReady = ur; halfRate = hr;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    chk(idle === 1'b1, "R10 idle before request", idle, 1);
    @(posedge clk); @(negedge clk);
    if (noise) begin
      reqAddr = ~a; reqWrite = ~wr; reqWdata = ~d;  // R11 request while busy
    end else reqValid = 1'b0;
    st = (hr && (cyc % 2 == 1)) ? 1 : 2;
    leadLeft = (L == 0) ? 1 : L; actLeft = A; trLeft = T;
    firstLead = 1'b1; endNow = 1'b0; guard = 0;
    while (!endNow && guard < 300) begin
      guard++;
      chk(csN === !(st >= 2), "R2 csN", csN, !(st >= 2));
      chk(rdN === !(st == 3 && !wr), "R9 rdN", rdN, !(st == 3 && !wr));
      chk(weN === !(st == 3 && wr), "R8 weN", weN, !(st == 3 && wr));
      chk(rnw === !(wr && st >= 3), "R8 rnw", rnw, !(wr && st >= 3));
      chk(busDoe === (wr && st >= 3), "R8 busDoe", busDoe, (wr && st >= 3));
      if (wr && st >= 3) chk(busDout === d, "R8 write data", busDout, d);
      chk(busAddr === a, "R7 address", busAddr, a);
      chk(idle === 1'b0 && done === 1'b0, "R11 busy flags", {idle, done}, 0);
      chk(busRise === riseExpected(hr, cyc), "R3 busRise", busRise, riseExpected(hr, cyc));
      if (st == 1) chk(csN && rdN && weN && rnw, "R4 align quiet", {csN, rdN, weN, rnw}, 4'hf);
      if (st == 2 && firstLead) begin
        chk(busRise === 1'b1, "R3 lead on rise", busRise, 1);
        firstLead = 1'b0;
      end
      busDin = 16'($urandom);
      readyIn = (($urandom % 100) >= lowPct);
      case (st)
        1: st = 2;
        2: begin
          leadLeft--;
          if (leadLeft == 0) begin
            if (!wr && A == 0) expRd = busDin;
            if (A != 0) st = 3; else if (T != 0) st = 4; else endNow = 1'b1;  // R12
          end
        end
        3: begin
          if (actLeft > 1) actLeft--;
          else if (!(ur && !readyIn)) begin  // R5 R6
            if (!wr) expRd = busDin;
            if (T != 0) st = 4; else endNow = 1'b1;
          end
        end
        default: begin
          trLeft--;
          if (trLeft == 0) endNow = 1'b1;
        end
      endcase
      @(posedge clk); @(negedge clk);
    end
    chk(done === 1'b1, "R10 done pulse", done, 1);
    chk(idle === 1'b1 && csN === 1'b1, "R10 idle at done", {idle, csN}, 3);
    chk(busAddr === a, "R7 address at done", busAddr, a);
    chk(rdData === expRd, "R9 read data", rdData, expRd);
    reqValid = 1'b0; readyIn = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", done, 0);
    chk(busAddr === a && csN === 1'b1, "R7 address held idle", busAddr, a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20110613));
    repeat (3) @(negedge clk);
    chk(csN && rdN && weN && rnw && !busDoe, "R1 reset strobes", {csN, rdN, weN, rnw, busDoe}, 5'h1e);
    chk(idle === 1'b1 && done === 1'b0, "R1 reset idle", {idle, done}, 2);
    chk(busAddr === '0 && rdData === '0, "R1 reset regs", busAddr, 0);
    rstN = 1'b1;
    @(negedge clk);
    // directed corners
    runAccess(1, 19'h12345, 16'hbeef, 2, 3, 2, 0, 0, 0, 0);     // R8 basic write
    runAccess(0, 19'h00abc, 16'h0, 1, 2, 1, 0, 0, 0, 0);        // R9 basic read
    runAccess(0, 19'h7ffff, 16'h0, 0, 0, 0, 0, 0, 0, 0);        // R2 R12 lead zero, all skip
    runAccess(1, 19'h00001, 16'h1234, 1, 0, 3, 0, 0, 0, 0);     // R12 no active
    runAccess(0, 19'h2aaaa, 16'h0, 2, 2, 0, 0, 0, 100, 0);      // R5 ready low ignored
    runAccess(0, 19'h15555, 16'h0, 1, 2, 1, 1, 0, 70, 0);       // R6 stretch
    runAccess(0, 19'h0f0f0, 16'h0, 1, 0, 2, 1, 0, 100, 0);      // R6 active zero ignores ready
    runAccess(1, 19'h33333, 16'h5a5a, 1, 1, 1, 0, 1, 0, 0);     // R3 R4 half rate
    @(negedge clk);
    runAccess(1, 19'h44444, 16'ha5a5, 1, 1, 1, 0, 1, 0, 0);     // R4 other parity
    runAccess(0, 19'h55555, 16'h0, 3, 2, 2, 0, 0, 0, 1);        // R11 noise while busy
    // random mix
    for (int i = 0; i < 60; i++) begin
      int gap;
      gap = $urandom % 3;
      repeat (gap) @(negedge clk);
      runAccess($urandom % 2, 19'($urandom), 16'($urandom), $urandom % 5, $urandom % 5,
                $urandom % 4, $urandom % 2, $urandom % 2, 40, $urandom % 2);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule